// File: doc/BRIEF.md
# Flash Housekeeping Command Sequencer

This block sits inside a serial NOR flash controller and runs, entirely in hardware, the two short housekeeping commands that every program or erase flow needs: fetching the status byte of a flash device and setting that device's write-enable latch. Software starts either command by writing the control word with one trigger bit set and a bank number, then waits for the completion flag. No software-built command bytes are involved.

The sequencer drives a mode-0 serial bus (clock idles low, data launched on the falling edge and captured on the rising edge) with one active-low select per bank. When a command finishes, its result is folded into a 16-bit controller status word. The received flash status byte goes in the low byte, and a per-bank write-mode bit goes in the high nibble. Completion and error flags sit between them. Two of those flags can raise an interrupt.

Top module: `hk_seq_top`

## Requirements
- R1: A control write with bit 10 set, software mode clear and the sequencer idle sends opcode 0x05 to the bank in control bits 13:12. Only that bank's select goes low, and the frame has 16 serial clock pulses (8 out, 8 in).
- R2: A control write with bit 11 set (bit 10 clear) sends opcode 0x06 to the selected bank in a frame of exactly 8 serial clock pulses.
- R3: After a read-status command, status bits 7:0 hold the byte received from the flash, first received bit in bit 7.
- R4: After a write-enable command to bank b, status bit 12+b is set and stays set until cleared. Other write-mode bits and the status byte are left unchanged.
- R5: Each completed command sets status bit 8 (transfer finished).
- R6: If bits 10 and 11 are both set in one write, only the read-status command is sent.
- R7: A trigger while software mode is set sends nothing, and the sequencer stays idle. Status bit 11 (forbidden access) is set.
- R8: A trigger while a command is in progress is dropped and sets status bit 10 (refused request). The running command completes normally.
- R9: A read-status reply with bit 0 (write in progress) clear sets status bit 9 (write complete). A reply with bit 0 set leaves bit 9 unchanged.
- R10: Every control write latches bit 8 as the transfer-finished interrupt enable and bit 9 as the write-complete interrupt enable. The interrupt output is high when an enabled flag is set.
- R11: A status clear pulse zeroes the whole status word. A completion or error event in the same cycle takes precedence over the clear.
- R12: After reset, all selects are high, the serial clock is low, the status word is zero, and busy and interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_mode_i | input | 1 | Software transfer mode active; blocks both commands |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_data_i | input | 16 | Control word: triggers, interrupt enables, bank |
| stat_clr_i | input | 1 | Clears the status word |
| stat_o | output | 16 | Controller status word |
| irq_o | output | 1 | Interrupt request |
| busy_o | output | 1 | Command accepted or in progress |
| flash_sck_o | output | 1 | Serial clock to the flash devices |
| flash_cs_n_o | output | 4 | Active-low select, one per bank |
| flash_mosi_o | output | 1 | Serial data to the flash |
| flash_miso_i | input | 1 | Serial data from the flash |

## Verification
A behavioural flash model records the opcode, the selected bank and the number of clock pulses in each frame. It answers status reads with a distinct byte per bank, so a wrong bank, a bit-order slip or a missing reply phase each show up as a different value. Read-status is run with replies that have the write-in-progress bit both set and clear, which separates the write-complete flag from plain completion. Write-enable goes to two banks back to back to show that write-mode bits accumulate. Further cases cover a combined trigger, a trigger in software mode, a trigger during a running command, and each interrupt enable on its own.

// File: rtl/hk_pkg.sv
package hk_pkg;

   typedef enum logic [1:0] {
      HK_IDLE,
      HK_SHIFT,
      HK_GAP
   } hk_state_e;

   typedef enum logic {
      HK_OP_RDSR,
      HK_OP_WREN
   } hk_op_e;

   localparam logic [7:0] HK_OPC_RDSR = 8'h05;
   localparam logic [7:0] HK_OPC_WREN = 8'h06;

   localparam int HK_CTRL_W     = 16;
   localparam int HK_STAT_W     = 16;
   localparam int HK_BIT_TFIE   = 8;
   localparam int HK_BIT_WCIE   = 9;
   localparam int HK_BIT_RDSR   = 10;
   localparam int HK_BIT_WREN   = 11;
   localparam int HK_BANK_LSB   = 12;
   localparam int HK_ST_TFF     = 8;
   localparam int HK_ST_WCF     = 9;
   localparam int HK_ST_REFUSED = 10;
   localparam int HK_ST_FORBID  = 11;
   localparam int HK_ST_WM_LSB  = 12;
   localparam int HK_MAX_BANKS  = 4;

endpackage

// File: rtl/hk_trigger.sv
module hk_trigger
   import hk_pkg::*;
#(
   parameter int NBANK  = 4,
   parameter int BANK_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ctl_wr_i,
   input  logic [HK_CTRL_W-1:0]  ctl_data_i,
   input  logic                  sw_mode_i,
   input  logic                  busy_i,
   output logic                  start_o,
   output hk_op_e                op_o,
   output logic [BANK_W-1:0]     bank_o,
   output logic                  err_forbid_o,
   output logic                  err_busy_o,
   output logic                  tfie_o,
   output logic                  wcie_o
);

   logic want_rd, want_we, want_any, accept;

   always_comb begin
      want_rd  = ctl_data_i[HK_BIT_RDSR];
      want_we  = ctl_data_i[HK_BIT_WREN];
      want_any = want_rd | want_we;
      accept   = ctl_wr_i && want_any && !sw_mode_i && !busy_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_o      <= 1'b0;
         op_o         <= HK_OP_RDSR;
         bank_o       <= '0;
         err_forbid_o <= 1'b0;
         err_busy_o   <= 1'b0;
         tfie_o       <= 1'b0;
         wcie_o       <= 1'b0;
      end else begin
         start_o      <= accept;
         err_forbid_o <= ctl_wr_i && want_any && sw_mode_i;
         err_busy_o   <= ctl_wr_i && want_any && !sw_mode_i && busy_i;
         if (ctl_wr_i) begin
            tfie_o <= ctl_data_i[HK_BIT_TFIE];
            wcie_o <= ctl_data_i[HK_BIT_WCIE];
         end
         if (accept) begin
            op_o   <= want_rd ? HK_OP_RDSR : HK_OP_WREN;
            bank_o <= ctl_data_i[HK_BANK_LSB +: BANK_W];
         end
      end
   end

   AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && ctl_data_i[HK_BIT_RDSR] && ctl_data_i[HK_BIT_WREN] && !sw_mode_i && !busy_i)
      |=> (start_o && op_o == HK_OP_RDSR)); // R6

   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> !start_o); // R8

endmodule

// File: rtl/hk_shifter.sv
module hk_shifter
   import hk_pkg::*;
#(
   parameter int NBANK   = 4,
   parameter int BANK_W  = 2,
   parameter int CLK_DIV = 2,
   parameter int GAP_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  hk_op_e            op_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic              miso_i,
   output logic              sck_o,
   output logic [NBANK-1:0]  cs_n_o,
   output logic              mosi_o,
   output logic              busy_o,
   output logic              done_o,
   output hk_op_e            done_op_o,
   output logic [BANK_W-1:0] done_bank_o,
   output logic [7:0]        rx_o
);

   localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int GAP_W  = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam int BIT_W  = 4;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
   localparam logic [BIT_W-1:0] LAST_RD  = BIT_W'(15);
   localparam logic [BIT_W-1:0] LAST_WE  = BIT_W'(7);
   localparam logic [BIT_W-1:0] REPLY_AT = BIT_W'(8);

   hk_state_e         state;
   hk_op_e            op_q;
   logic [BANK_W-1:0] bank_q;
   logic [7:0]        tx_sr, rx_sr;
   logic [BIT_W-1:0]  bitcnt, last_bit;
   logic [DIV_W-1:0]  divcnt;
   logic [GAP_W-1:0]  gapcnt;
   logic              sck_q, done_q;

   assign last_bit = (op_q == HK_OP_RDSR) ? LAST_RD : LAST_WE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= HK_IDLE;
         op_q   <= HK_OP_RDSR;
         bank_q <= '0;
         tx_sr  <= '0;
         rx_sr  <= '0;
         bitcnt <= '0;
         divcnt <= '0;
         gapcnt <= '0;
         sck_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            HK_IDLE: begin
               if (start_i) begin
                  state  <= HK_SHIFT;
                  op_q   <= op_i;
                  bank_q <= bank_i;
                  tx_sr  <= (op_i == HK_OP_RDSR) ? HK_OPC_RDSR : HK_OPC_WREN;
                  rx_sr  <= '0;
                  bitcnt <= '0;
                  divcnt <= '0;
                  sck_q  <= 1'b0;
               end
            end
            HK_SHIFT: begin
               if (divcnt == DIV_LAST) begin
                  divcnt <= '0;
                  if (!sck_q) begin
                     sck_q <= 1'b1;
                     if (bitcnt >= REPLY_AT)
                        rx_sr <= {rx_sr[6:0], miso_i};
                  end else begin
                     sck_q <= 1'b0;
                     tx_sr <= {tx_sr[6:0], 1'b0};
                     if (bitcnt == last_bit) begin
                        state  <= HK_GAP;
                        gapcnt <= '0;
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end else begin
                  divcnt <= divcnt + 1'b1;
               end
            end
            HK_GAP: begin
               if (gapcnt == GAP_LAST) begin
                  state  <= HK_IDLE;
                  done_q <= 1'b1;
               end else begin
                  gapcnt <= gapcnt + 1'b1;
               end
            end
            default: state <= HK_IDLE;
         endcase
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_sel
      assign cs_n_o[b] = !((state == HK_SHIFT) && (bank_q == BANK_W'(b)));
   end

   assign sck_o       = sck_q;
   assign mosi_o      = (state == HK_SHIFT) ? tx_sr[7] : 1'b0;
   assign busy_o      = (state != HK_IDLE);
   assign done_o      = done_q;
   assign done_op_o   = op_q;
   assign done_bank_o = bank_q;
   assign rx_o        = rx_sr;

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n_o) <= 1); // R1

   AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n_o) |-> !sck_o); // R12

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (&cs_n_o)); // R5

endmodule

// File: rtl/hk_status.sv
module hk_status
   import hk_pkg::*;
#(
   parameter int NBANK  = 4,
   parameter int BANK_W = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done_i,
   input  hk_op_e               done_op_i,
   input  logic [BANK_W-1:0]    done_bank_i,
   input  logic [7:0]           rx_i,
   input  logic                 err_forbid_i,
   input  logic                 err_busy_i,
   input  logic                 clr_i,
   input  logic                 tfie_i,
   input  logic                 wcie_i,
   output logic [HK_STAT_W-1:0] stat_o,
   output logic                 irq_o
);

   logic [HK_STAT_W-1:0] stat_q, stat_nxt;

   always_comb begin
      stat_nxt = clr_i ? '0 : stat_q;
      if (done_i) begin
         stat_nxt[HK_ST_TFF] = 1'b1;
         if (done_op_i == HK_OP_RDSR) begin
            stat_nxt[7:0] = rx_i;
            if (!rx_i[0])
               stat_nxt[HK_ST_WCF] = 1'b1;
         end else begin
            for (int b = 0; b < NBANK; b++)
               if (done_bank_i == BANK_W'(b))
                  stat_nxt[HK_ST_WM_LSB + b] = 1'b1;
         end
      end
      if (err_busy_i)
         stat_nxt[HK_ST_REFUSED] = 1'b1;
      if (err_forbid_i)
         stat_nxt[HK_ST_FORBID] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_nxt;
   end

   assign stat_o = stat_q;
   assign irq_o  = (stat_q[HK_ST_TFF] & tfie_i) | (stat_q[HK_ST_WCF] & wcie_i);

   AST_TFF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> stat_o[HK_ST_TFF]); // R5

   AST_FORBID_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      err_forbid_i |=> stat_o[HK_ST_FORBID]); // R7

   AST_REFUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      err_busy_i |=> stat_o[HK_ST_REFUSED]); // R8

   for (genvar b = 0; b < NBANK; b++) begin : g_wm_chk
      AST_WM_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (done_i && done_op_i == HK_OP_WREN && done_bank_i == BANK_W'(b))
         |=> stat_o[HK_ST_WM_LSB + b]); // R4
   end

endmodule

// File: rtl/hk_seq_top.sv
module hk_seq_top
   import hk_pkg::*;
#(
   parameter int NBANK   = 4,
   parameter int CLK_DIV = 2,
   parameter int GAP_CYC = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sw_mode_i,
   input  logic                  ctl_wr_i,
   input  logic [HK_CTRL_W-1:0]  ctl_data_i,
   input  logic                  stat_clr_i,
   output logic [HK_STAT_W-1:0]  stat_o,
   output logic                  irq_o,
   output logic                  busy_o,
   output logic                  flash_sck_o,
   output logic [NBANK-1:0]      flash_cs_n_o,
   output logic                  flash_mosi_o,
   input  logic                  flash_miso_i
);

   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

   if (NBANK < 1 || NBANK > HK_MAX_BANKS) begin : g_bad_nbank
      $error("hk_seq_top: NBANK must be 1..4");
   end
   if (CLK_DIV < 1) begin : g_bad_div
      $error("hk_seq_top: CLK_DIV must be at least 1");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("hk_seq_top: GAP_CYC must be at least 1");
   end

   logic              start, eng_busy, done, err_forbid, err_busy, tfie, wcie;
   hk_op_e            op, done_op;
   logic [BANK_W-1:0] bank, done_bank;
   logic [7:0]        rx;

   assign busy_o = eng_busy | start;

   hk_trigger #(.NBANK(NBANK), .BANK_W(BANK_W)) i_trigger (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_wr_i     (ctl_wr_i),
      .ctl_data_i   (ctl_data_i),
      .sw_mode_i    (sw_mode_i),
      .busy_i       (busy_o),
      .start_o      (start),
      .op_o         (op),
      .bank_o       (bank),
      .err_forbid_o (err_forbid),
      .err_busy_o   (err_busy),
      .tfie_o       (tfie),
      .wcie_o       (wcie)
   );

   hk_shifter #(.NBANK(NBANK), .BANK_W(BANK_W), .CLK_DIV(CLK_DIV), .GAP_CYC(GAP_CYC)) i_shifter (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .op_i        (op),
      .bank_i      (bank),
      .miso_i      (flash_miso_i),
      .sck_o       (flash_sck_o),
      .cs_n_o      (flash_cs_n_o),
      .mosi_o      (flash_mosi_o),
      .busy_o      (eng_busy),
      .done_o      (done),
      .done_op_o   (done_op),
      .done_bank_o (done_bank),
      .rx_o        (rx)
   );

   hk_status #(.NBANK(NBANK), .BANK_W(BANK_W)) i_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .done_i       (done),
      .done_op_i    (done_op),
      .done_bank_i  (done_bank),
      .rx_i         (rx),
      .err_forbid_i (err_forbid),
      .err_busy_i   (err_busy),
      .clr_i        (stat_clr_i),
      .tfie_i       (tfie),
      .wcie_i       (wcie),
      .stat_o       (stat_o),
      .irq_o        (irq_o)
   );

   AST_SW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr_i && sw_mode_i && !busy_o) |=> !busy_o); // R7

endmodule

// File: tb/test_hk_seq_top.sv
module test_hk_seq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_mode = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_data = '0;
   logic        stat_clr = 1'b0;
   logic [15:0] stat;
   logic        irq, busy, sck, mosi;
   logic        miso = 1'b0;
   logic [3:0]  cs_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   hk_seq_top i_hk_seq_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_mode_i    (sw_mode),
      .ctl_wr_i     (ctl_wr),
      .ctl_data_i   (ctl_data),
      .stat_clr_i   (stat_clr),
      .stat_o       (stat),
      .irq_o        (irq),
      .busy_o       (busy),
      .flash_sck_o  (sck),
      .flash_mosi_o (mosi),
      .flash_cs_n_o (cs_n),
      .flash_miso_i (miso)
   );

   // flash model
   logic [7:0] reply [4];
   logic [7:0] m_op;
   int         m_cnt = 0;
   int         m_bank = -1;
   int         m_frames = 0;
   wire        any_sel = ~&cs_n;

   always @(posedge any_sel) begin
      m_cnt = 0;
      m_op  = 8'h00;
      m_frames++;
      for (int b = 0; b < 4; b++) if (!cs_n[b]) m_bank = b;
   end
   always @(posedge sck) if (any_sel) begin
      if (m_cnt < 8) m_op = {m_op[6:0], mosi};
      m_cnt++;
   end
   always @(negedge sck) if (any_sel && m_cnt >= 8 && m_cnt < 16)
      miso <= reply[m_bank][15 - m_cnt];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (busy && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(n < 2000, "watchdog idle", n, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic write_ctl(input logic [15:0] d);
      @(negedge clk);
      ctl_data = d;
      ctl_wr   = 1'b1;
      @(negedge clk);
      ctl_wr   = 1'b0;
      ctl_data = '0;
   endtask

   task automatic clear_stat();
      @(negedge clk);
      stat_clr = 1'b1;
      @(negedge clk);
      stat_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(stat == 16'h0, "R12 status", stat, 0);
      chk(cs_n == 4'hF, "R12 selects", cs_n, 4'hF);
      chk(!sck && !busy && !irq, "R12 sck/busy/irq", {sck, busy, irq}, 0);
   endtask

   task automatic t_rdsr(input int bank, input logic [7:0] val);
      reply[bank] = val;
      clear_stat();
      write_ctl(16'(bank << 12) | 16'h0400);
      wait_idle();
      chk(m_op == 8'h05, "R1 opcode", m_op, 8'h05);
      chk(m_bank == bank, "R1 bank", m_bank, bank);
      chk(m_cnt == 16, "R1 pulses", m_cnt, 16);
      chk(stat[7:0] == val, "R3 status byte", stat[7:0], val);
      chk(stat[8], "R5 done flag", stat[8], 1);
      chk(stat[9] == !val[0], "R9 write complete", stat[9], !val[0]);
   endtask

   task automatic t_wren();
      clear_stat();
      write_ctl(16'h2800);
      wait_idle();
      chk(m_op == 8'h06, "R2 opcode", m_op, 8'h06);
      chk(m_cnt == 8, "R2 pulses", m_cnt, 8);
      chk(m_bank == 2, "R2 bank", m_bank, 2);
      chk(stat == 16'h4100, "R4 bank2 only", stat, 16'h4100);
      write_ctl(16'h0800);
      wait_idle();
      chk(stat == 16'h5100, "R4 accumulate", stat, 16'h5100);
   endtask

   task automatic t_both();
      reply[1] = 8'h03;
      clear_stat();
      write_ctl(16'h1C00);
      wait_idle();
      chk(m_op == 8'h05, "R6 priority opcode", m_op, 8'h05);
      chk(stat == 16'h0103, "R6 no write mode", stat, 16'h0103);
   endtask

   task automatic t_swmode();
      int f;
      clear_stat();
      f = m_frames;
      sw_mode = 1'b1;
      write_ctl(16'h0400);
      chk(!busy, "R7 idle", busy, 0);
      wait_idle();
      sw_mode = 1'b0;
      chk(m_frames == f, "R7 no frame", m_frames, f);
      chk(stat == 16'h0800, "R7 forbid flag", stat, 16'h0800);
   endtask

   task automatic t_busy();
      int f;
      reply[3] = 8'h01;
      clear_stat();
      f = m_frames;
      write_ctl(16'h3400);
      repeat (3) @(negedge clk);
      write_ctl(16'h0800);
      wait_idle();
      chk(m_frames == f + 1, "R8 one frame", m_frames, f + 1);
      chk(m_op == 8'h05, "R8 first kept", m_op, 8'h05);
      chk(stat == 16'h0501, "R8 refused flag", stat, 16'h0501);
   endtask

   task automatic t_irq();
      reply[0] = 8'h01;
      clear_stat();
      write_ctl(16'h0500);
      wait_idle();
      chk(irq, "R10 tff irq", irq, 1);
      clear_stat();
      chk(!irq && stat == 0, "R11 clear", {irq, stat}, 0);
      write_ctl(16'h0600);
      wait_idle();
      chk(!irq, "R10 wcf masked", irq, 0);
      reply[0] = 8'h00;
      write_ctl(16'h0600);
      wait_idle();
      chk(irq && stat[9], "R10 wcf irq", {irq, stat[9]}, 3);
   endtask

   initial begin
      #(200000 * 8);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int b = 0; b < 4; b++) reply[b] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_rdsr(0, 8'h9C);
      t_rdsr(3, 8'h03);
      t_rdsr(1, 8'hA5);
      t_wren();
      t_both();
      t_swmode();
      t_busy();
      t_irq();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule